// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block is the exception control of an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. Next to each instruction it keeps a valid bit, a PC and a pending fault with its code. Each stage can detect one kind of fault. Fetch flags a bad instruction address, decode flags an unknown opcode, execute flags arithmetic overflow and memory flags a bad data address. A detected fault is only recorded on the instruction. Nothing acts on it while the instruction is still in the early stages.

All decisions are made in the memory stage, which is the single commit point. An external interrupt request wins over every fault. A fault recorded in an earlier stage wins over one found later. When something is taken, the block does four things. It loads a cause register and an exception PC register. It turns every younger instruction in fetch, decode and execute into a bubble. It blocks the writeback of the faulting instruction. On the next cycle it tells the fetch logic to jump to a fixed handler address. The fetch logic outside the block presents each fetched instruction, and it obeys the redirect pulse.

The pipeline advances one stage every cycle. The datapath itself is outside this block.

Top module: `exc_commit_ctrl`

## Requirements
- R1: A fault found in fetch, decode or execute causes no flush while the instruction is in those stages. The flush (`flush_front_o` high) happens only in the cycle that instruction occupies the memory stage, three cycles after it entered fetch.
- R2: When one instruction has faults from several stages, the cause recorded is the one from the earliest stage.
- R3: An interrupt request present while a valid instruction sits in the memory stage is taken with cause 0, even if that instruction has a fault of its own.
- R4: Cause codes are 0 for interrupt, 1 for fetch address fault, 2 for illegal opcode, 3 for overflow and 4 for data address fault. In the cycle after a taken exception, `cause_o` holds the code and `epc_o` holds the PC of the instruction in the memory stage. Both keep their values until the next taken exception.
- R5: Instructions in fetch, decode or execute during a flush never reach writeback. Any faults they carry are discarded, so they cause no later exception.
- R6: The instruction that takes the exception or interrupt does not appear on `wb_valid_o`.
- R7: `redirect_o` is high for exactly the one cycle after a taken exception, with `redirect_pc_o` equal to the handler address (default 0x180). At all other times it is low.
- R8: An interrupt request has no effect while the memory stage holds no valid instruction.
- R9: A fault-free instruction fetched in cycle n appears on `mem_valid_o`/`mem_pc_o` in cycle n+3 and on `wb_valid_o`/`wb_pc_o` in cycle n+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid_i | input | 1 | An instruction occupies fetch this cycle |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_addr_fault_i | input | 1 | Fetch address fault for that instruction |
| id_illegal_i | input | 1 | Decode found an illegal opcode |
| ex_overflow_i | input | 1 | Execute found arithmetic overflow |
| mem_addr_fault_i | input | 1 | Memory found a data address fault |
| irq_i | input | 1 | External interrupt request |
| flush_front_o | output | 1 | Exception taken now; fetch, decode and execute are killed |
| redirect_o | output | 1 | Fetch must load the handler address this cycle |
| redirect_pc_o | output | PC_W | Handler address |
| cause_o | output | 3 | Cause register |
| epc_o | output | PC_W | Exception PC register |
| wb_valid_o | output | 1 | An instruction is written back this cycle |
| wb_pc_o | output | PC_W | PC of the instruction in writeback |
| mem_valid_o | output | 1 | Memory stage holds a valid instruction |
| mem_pc_o | output | PC_W | PC of the instruction in the memory stage |

## Verification
Two situations are hard to reach from the ports. The first needs several faults on one instruction. The second needs a fault-carrying instruction sitting behind one that is about to be flushed. Each fault input only acts on whatever is in its stage during that cycle, so the bench schedules the stimulus against a cycle count from the fetch of the target instruction. It raises decode faults one cycle after fetch, execute faults two cycles after, and memory faults and interrupts three cycles after. The kill scenario puts a second instruction with its own fetch fault right behind an illegal one. It then checks that the younger instruction never flushes, never retires and never reaches the memory stage.

// File: rtl/exc_ctrl_pkg.sv
// Package: shared cause encoding for the exception commit controller.
// Assumes a three-bit cause field; code values are fixed by the requirements.
package exc_ctrl_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ     = 3'd0,
        CAUSE_FETCH   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DADDR   = 3'd4
    } cause_e;

endpackage

// File: rtl/exc_pipe_slot.sv
// Module: one pipeline register that carries an instruction's valid bit, PC
// and pending fault. Its output merges in this stage's own fault, but only
// when no earlier fault is already pending. Assumes the pipeline advances
// every cycle. A kill turns the captured entry into a bubble with no fault.
module exc_pipe_slot
    import exc_ctrl_pkg::*;
#(
    parameter int     PC_W       = 32,
    parameter cause_e LOCAL_CODE = CAUSE_ILLEGAL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill_i,
    input  logic            in_valid_i,
    input  logic [PC_W-1:0] in_pc_i,
    input  logic            in_pend_i,
    input  cause_e          in_code_i,
    input  logic            fault_i,
    output logic            out_valid_o,
    output logic [PC_W-1:0] out_pc_o,
    output logic            out_pend_o,
    output cause_e          out_code_o
);

    logic            valid_q;
    logic [PC_W-1:0] pc_q;
    logic            pend_q;
    cause_e          code_q;

    // Capture the entry from the previous stage, or a bubble when killed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pc_q    <= '0;
            pend_q  <= 1'b0;
            code_q  <= CAUSE_IRQ;
        end else if (kill_i) begin
            valid_q <= 1'b0;
            pc_q    <= '0;
            pend_q  <= 1'b0;
            code_q  <= CAUSE_IRQ;
        end else begin
            valid_q <= in_valid_i;
            pc_q    <= in_pc_i;
            pend_q  <= in_valid_i && in_pend_i;
            code_q  <= in_code_i;
        end
    end

    // Merge this stage's fault; an older pending fault keeps priority.
    always_comb begin
        out_valid_o = valid_q;
        out_pc_o    = pc_q;
        out_pend_o  = valid_q && (pend_q || fault_i);
        out_code_o  = pend_q ? code_q : LOCAL_CODE;
    end

    // A killed entry leaves no instruction and no fault behind.
    p_kill_makes_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (!out_valid_o && !out_pend_o));

    // A fault that arrives pending keeps its code, whatever this stage finds.
    p_older_fault_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_pend_i && !kill_i) |=>
            (out_pend_o && out_code_o == $past(in_code_i)));

endmodule

// File: rtl/exc_commit_arbiter.sv
// Module: commit point at the memory stage. It decides whether an interrupt
// or a fault is taken, keeps the cause and exception PC registers, produces
// the one-cycle handler redirect, and holds the writeback register. Assumes
// the memory stage entry is already merged with its own fault.
module exc_commit_arbiter
    import exc_ctrl_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            m_valid_i,
    input  logic [PC_W-1:0] m_pc_i,
    input  logic            m_pend_i,
    input  cause_e          m_code_i,
    input  logic            irq_i,
    output logic            take_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output cause_e          cause_o,
    output logic [PC_W-1:0] epc_o,
    output logic            wb_valid_o,
    output logic [PC_W-1:0] wb_pc_o
);

    logic            irq_hit;
    cause_e          cause_d;
    logic            redirect_q;
    cause_e          cause_q;
    logic [PC_W-1:0] epc_q;
    logic            wb_valid_q;
    logic [PC_W-1:0] wb_pc_q;

    // Decide what is taken at commit; an interrupt wins over any fault.
    always_comb begin
        irq_hit = m_valid_i && irq_i;
        take_o  = irq_hit || (m_valid_i && m_pend_i);
        cause_d = irq_hit ? CAUSE_IRQ : m_code_i;
    end

    // Record the cause and the PC of the instruction at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_IRQ;
            epc_q   <= '0;
        end else if (take_o) begin
            cause_q <= cause_d;
            epc_q   <= m_pc_i;
        end
    end

    // Raise the handler redirect for the cycle after a taken exception.
    always_ff @(posedge clk) begin
        if (!rst_n) redirect_q <= 1'b0;
        else        redirect_q <= take_o;
    end

    // Pass a committing instruction to writeback unless it excepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_q <= 1'b0;
            wb_pc_q    <= '0;
        end else begin
            wb_valid_q <= m_valid_i && !take_o;
            wb_pc_q    <= m_pc_i;
        end
    end

    // Drive the registered state onto the outputs.
    always_comb begin
        redirect_o    = redirect_q;
        redirect_pc_o = HANDLER_PC;
        cause_o       = cause_q;
        epc_o         = epc_q;
        wb_valid_o    = wb_valid_q;
        wb_pc_o       = wb_pc_q;
    end

    p_irq_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_i && irq_i) |=> (cause_o == CAUSE_IRQ));

    p_epc_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (epc_o == $past(m_pc_i)));

    p_no_wb_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !wb_valid_o);

    p_redirect_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> redirect_o);

    p_redirect_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |=> !redirect_o);

    p_irq_needs_instr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid_i) |-> !take_o);

endmodule

// File: rtl/exc_commit_ctrl.sv
// Module: top of the precise exception controller. It chains the decode,
// execute and memory slots, applies the fetch fault on entry, and connects
// the commit arbiter. A taken exception kills the entries that would move
// into decode, execute and memory. Assumes one advance per cycle and that
// the fetch logic obeys redirect_o.
module exc_commit_ctrl
    import exc_ctrl_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                if_valid_i,
    input  logic [PC_W-1:0]     if_pc_i,
    input  logic                if_addr_fault_i,
    input  logic                id_illegal_i,
    input  logic                ex_overflow_i,
    input  logic                mem_addr_fault_i,
    input  logic                irq_i,
    output logic                flush_front_o,
    output logic                redirect_o,
    output logic [PC_W-1:0]     redirect_pc_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [PC_W-1:0]     epc_o,
    output logic                wb_valid_o,
    output logic [PC_W-1:0]     wb_pc_o,
    output logic                mem_valid_o,
    output logic [PC_W-1:0]     mem_pc_o
);

    localparam int NSLOT = 3;

    logic            f_pend;
    logic            take;
    cause_e          cause_s;
    logic            s_valid [NSLOT+1];
    logic [PC_W-1:0] s_pc    [NSLOT+1];
    logic            s_pend  [NSLOT+1];
    cause_e          s_code  [NSLOT+1];
    logic            s_fault [NSLOT];

    // Form the fetch entry and route each stage's local fault input.
    always_comb begin
        f_pend     = if_valid_i && if_addr_fault_i;
        s_valid[0] = if_valid_i;
        s_pc[0]    = if_pc_i;
        s_pend[0]  = f_pend;
        s_code[0]  = CAUSE_FETCH;
        s_fault[0] = id_illegal_i;
        s_fault[1] = ex_overflow_i;
        s_fault[2] = mem_addr_fault_i;
    end

    // One slot each for decode, execute and memory, each with its fault code.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam cause_e CODE = (g == 0) ? CAUSE_ILLEGAL :
                                  (g == 1) ? CAUSE_OVF : CAUSE_DADDR;
        exc_pipe_slot #(
            .PC_W       (PC_W),
            .LOCAL_CODE (CODE)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .kill_i      (take),
            .in_valid_i  (s_valid[g]),
            .in_pc_i     (s_pc[g]),
            .in_pend_i   (s_pend[g]),
            .in_code_i   (s_code[g]),
            .fault_i     (s_fault[g]),
            .out_valid_o (s_valid[g+1]),
            .out_pc_o    (s_pc[g+1]),
            .out_pend_o  (s_pend[g+1]),
            .out_code_o  (s_code[g+1])
        );
    end

    exc_commit_arbiter #(
        .PC_W       (PC_W),
        .HANDLER_PC (HANDLER_PC)
    ) u_commit (
        .clk           (clk),
        .rst_n         (rst_n),
        .m_valid_i     (s_valid[NSLOT]),
        .m_pc_i        (s_pc[NSLOT]),
        .m_pend_i      (s_pend[NSLOT]),
        .m_code_i      (s_code[NSLOT]),
        .irq_i         (irq_i),
        .take_o        (take),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .cause_o       (cause_s),
        .epc_o         (epc_o),
        .wb_valid_o    (wb_valid_o),
        .wb_pc_o       (wb_pc_o)
    );

    // Expose the commit decision and the memory stage occupant.
    always_comb begin
        flush_front_o = take;
        cause_o       = cause_s;
        mem_valid_o   = s_valid[NSLOT];
        mem_pc_o      = s_pc[NSLOT];
    end

    // A flush is only possible with a valid instruction at commit.
    p_flush_at_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush_front_o |-> mem_valid_o);

    // The cause register only ever holds a defined code.
    p_cause_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o <= 3'd4);

endmodule

// File: tb/tb_exc_commit_ctrl.sv
module tb_exc_commit_ctrl;

    localparam int          PC_W    = 32;
    localparam logic [31:0] HANDLER = 32'h0000_0180;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            if_valid_i = 1'b0;
    logic [PC_W-1:0] if_pc_i = '0;
    logic            if_addr_fault_i = 1'b0;
    logic            id_illegal_i = 1'b0;
    logic            ex_overflow_i = 1'b0;
    logic            mem_addr_fault_i = 1'b0;
    logic            irq_i = 1'b0;
    logic            flush_front_o;
    logic            redirect_o;
    logic [PC_W-1:0] redirect_pc_o;
    logic [2:0]      cause_o;
    logic [PC_W-1:0] epc_o;
    logic            wb_valid_o;
    logic [PC_W-1:0] wb_pc_o;
    logic            mem_valid_o;
    logic [PC_W-1:0] mem_pc_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) dut (
        .clk(clk), .rst_n(rst_n),
        .if_valid_i(if_valid_i), .if_pc_i(if_pc_i),
        .if_addr_fault_i(if_addr_fault_i), .id_illegal_i(id_illegal_i),
        .ex_overflow_i(ex_overflow_i), .mem_addr_fault_i(mem_addr_fault_i),
        .irq_i(irq_i), .flush_front_o(flush_front_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .cause_o(cause_o), .epc_o(epc_o),
        .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o),
        .mem_valid_o(mem_valid_o), .mem_pc_o(mem_pc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs shortly after a falling edge.
    task automatic drive(input logic v, input logic [31:0] pc, input logic ff,
                         input logic ill, input logic ovf, input logic maf, input logic irq);
        if_valid_i = v; if_pc_i = pc; if_addr_fault_i = ff;
        id_illegal_i = ill; ex_overflow_i = ovf; mem_addr_fault_i = maf; irq_i = irq;
        #1;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 0, 0, 0, 0);
            next_cycle();
        end
    endtask

    // One instruction with faults scheduled at each stage; checks commit outcome.
    task automatic run_one(input string tag, input logic [31:0] pc, input logic ff,
                           input logic ill, input logic ovf, input logic maf,
                           input logic irq, input logic take, input logic [2:0] cause);
        drive(1, pc, ff, 0, 0, 0, 0);
        check({tag, " R1 no flush at fetch"}, flush_front_o, 0);
        next_cycle();
        drive(0, 0, 0, ill, 0, 0, 0);
        check({tag, " R1 no flush at decode"}, flush_front_o, 0);
        next_cycle();
        drive(0, 0, 0, 0, ovf, 0, 0);
        check({tag, " R1 no flush at execute"}, flush_front_o, 0);
        next_cycle();
        drive(0, 0, 0, 0, 0, maf, irq);
        check({tag, " R9 mem valid"}, mem_valid_o, 1);
        check({tag, " R9 mem pc"}, mem_pc_o, pc);
        check({tag, " R1 flush at commit"}, flush_front_o, take);
        next_cycle();
        drive(0, 0, 0, 0, 0, 0, 0);
        check({tag, " R7 redirect"}, redirect_o, take);
        check({tag, " R6 writeback"}, wb_valid_o, !take);
        if (take) begin
            check({tag, " R4 cause"}, cause_o, cause);
            check({tag, " R4 epc"}, epc_o, pc);
            check({tag, " R7 handler pc"}, redirect_pc_o, HANDLER);
        end else begin
            check({tag, " R9 wb pc"}, wb_pc_o, pc);
        end
        next_cycle();
        check({tag, " R7 redirect single"}, redirect_o, 0);
        idle(2);
    endtask

    task automatic t_reset();
        check("R7 reset redirect", redirect_o, 0);
        check("R6 reset wb", wb_valid_o, 0);
        check("R9 reset mem", mem_valid_o, 0);
        check("R4 reset cause", cause_o, 0);
        check("R4 reset epc", epc_o, 0);
    endtask

    task automatic t_clean();
        run_one("clean", 32'h100, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_single_faults();
        run_one("fetch", 32'h110, 1, 0, 0, 0, 0, 1, 3'd1);
        run_one("illegal", 32'h120, 0, 1, 0, 0, 0, 1, 3'd2);
        run_one("ovf", 32'h130, 0, 0, 1, 0, 0, 1, 3'd3);
        run_one("daddr", 32'h140, 0, 0, 0, 1, 0, 1, 3'd4);
    endtask

    task automatic t_priority();
        run_one("R2 all", 32'h150, 1, 1, 1, 1, 0, 1, 3'd1);
        run_one("R2 ill+maf", 32'h160, 0, 1, 0, 1, 0, 1, 3'd2);
        run_one("R2 ovf+maf", 32'h170, 0, 0, 1, 1, 0, 1, 3'd3);
    endtask

    task automatic t_irq();
        run_one("R3 irq over fault", 32'h200, 0, 1, 0, 1, 1, 1, 3'd0);
        run_one("R3 irq clean", 32'h210, 0, 0, 0, 0, 1, 1, 3'd0);
    endtask

    // Interrupt against an empty memory stage has no effect (R8).
    task automatic t_irq_bubble();
        logic [31:0] c0, e0;
        c0 = cause_o; e0 = epc_o;
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R8 no flush on bubble", flush_front_o, 0);
        next_cycle();
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R8 no redirect", redirect_o, 0);
        check("R8 cause held", cause_o, c0);
        check("R8 epc held", epc_o, e0);
        next_cycle();
        idle(1);
    endtask

    // Younger instructions behind an excepting one are killed (R5).
    task automatic t_kill();
        drive(1, 32'h300, 0, 0, 0, 0, 0); next_cycle();
        drive(1, 32'h304, 1, 1, 0, 0, 0); next_cycle();
        drive(1, 32'h308, 0, 0, 0, 0, 0); next_cycle();
        drive(1, 32'h30C, 0, 0, 0, 0, 0);
        check("R5 flush for older", flush_front_o, 1);
        check("R5 mem pc", mem_pc_o, 32'h300);
        next_cycle();
        drive(0, 0, 0, 0, 0, 0, 0);
        check("R5 cause", cause_o, 3'd2);
        check("R5 epc", epc_o, 32'h300);
        next_cycle();
        for (int i = 0; i < 5; i++) begin
            drive(0, 0, 0, 0, 0, 0, 0);
            check("R5 no second flush", flush_front_o, 0);
            check("R5 no killed retire", wb_valid_o, 0);
            check("R5 no killed in mem", mem_valid_o, 0);
            next_cycle();
        end
        check("R4 cause held", cause_o, 3'd2);
        check("R4 epc held", epc_o, 32'h300);
    endtask

    // Back-to-back clean instructions all retire in order (R9).
    task automatic t_stream();
        for (int i = 0; i < 4; i++) begin
            drive(1, 32'h400 + 4 * i, 0, 0, 0, 0, 0);
            if (i >= 3) check("R9 stream mem", mem_pc_o, 32'h400);
            next_cycle();
        end
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 0, 0, 0, 0, 0);
            check("R9 stream wb valid", wb_valid_o, 1);
            check("R9 stream wb pc", wb_pc_o, 32'h400 + 4 * i);
            next_cycle();
        end
        check("R4 cause unchanged by retire", cause_o, 3'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        next_cycle();
        t_clean();
        t_single_faults();
        t_priority();
        t_irq();
        t_irq_bubble();
        t_kill();
        t_stream();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule